// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block takes one active-low interrupt pin from outside the chip, brings it into the core clock domain and turns it into an interrupt request for the processor. A single 8-bit control register, reached over a simple register bus with address, write strobe, write data and combinational read data, chooses between two ways of recognising the pin. In level mode a low pin requests service. In edge mode a falling edge is captured and held. The same register can also cut the pin off from the request logic.

A mode input tells the block whether the chip runs in a special (test) mode or in a normal mode. In normal mode the sensitivity choice can be written once after reset and is then frozen. In special mode it stays writable. The processor's service acknowledge pulse releases a captured edge. A reserved address next to the control register reads as zero and ignores writes. Vectoring, priority and masking inside the processor are outside this block.

Top module: `extirq_ctrl`

## Requirements
- R1: The control register at address CTRL_ADDR (default 0x1E) reads as {sensitivity, enable, 6'b0}. Bit 7 is sensitivity (0 = level, 1 = falling edge) and bit 6 is enable (1 = pin connected). Bits 5..0 always read 0 and ignore writes.
- R2: After reset the control register reads 0x40 (level mode, enabled) and irqReq is 0 while the pin is high.
- R3: The reserved address RSVD_ADDR (default 0x0F), and every other address that is not CTRL_ADDR, reads 0x00. Writes there change no readable state.
- R4: In level mode with enable 1, irqReq is 1 exactly while the synchronised pin is low. A pin driven low before clock edge k gives irqReq = 1 after edge k+1.
- R5: In edge mode with enable 1, a falling edge of the synchronised pin sets a latch. A pin falling before edge k gives irqReq = 1 after edge k+2. The request then stays 1 after the pin returns high, until service or reset.
- R6: A one-cycle svcAck clears the edge latch. If a new falling edge is seen in the same cycle, the latch stays set.
- R7: While enable is 0, irqReq is 0 and the edge latch is held clear. Enabling again does not bring back an edge that was captured earlier.
- R8: With specialMode = 1, the sensitivity bit can be written any number of times.
- R9: With specialMode = 0, the first write to the control register after reset sets a lock, even if that write leaves bit 7 unchanged. Later writes cannot change sensitivity but still change enable. The lock clears only on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| specialMode | input | 1 | 1 = special mode, 0 = normal mode |
| pinN | input | 1 | External active-low interrupt pin, asynchronous |
| busAddr | input | ADDR_W | Register address |
| busWr | input | 1 | Write strobe |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for busAddr, combinational |
| svcAck | input | 1 | Interrupt service acknowledge pulse |
| irqReq | output | 1 | Interrupt request to the processor |

## Verification
On every cycle, the assertions check the zero fields on reads and the reserved address. They also check that the request follows the synchronised pin in level mode and the latch in edge mode, that a disabled pin keeps the latch clear, and that a locked sensitivity bit holds through writes. They further check that an acknowledge with no edge present clears the latch, and that the latch holds without one. Only the bench scenarios can show the behaviour across a sequence: the first write locks in normal mode while special mode stays open, the exact synchroniser latency, an acknowledge that meets a new edge in the same cycle, and a re-enable that does not bring back an old edge.

// File: rtl/extirq_pkg.sv
package extirq_pkg;
  localparam int DATA_W   = 8;
  localparam int SENS_POS = 7;
  localparam int EN_POS   = 6;
  localparam logic [DATA_W-1:0] RESET_VAL = 8'h40;
  localparam logic [DATA_W-1:0] FULL_MASK = 8'hC0;
  localparam logic [DATA_W-1:0] EN_MASK   = 8'h40;

  typedef struct packed {
    logic sensEdge;   // 1: falling-edge recognition
    logic pinEnable;  // 1: pin connected to request logic
  } irqCtl_t;
endpackage

// File: rtl/extirq_ctl.sv
module extirq_ctl
  import extirq_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 5'h1E,
  parameter logic [ADDR_W-1:0] RSVD_ADDR = 5'h0F
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              specialMode,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output irqCtl_t           ctlStrobe,
  output logic              lockFlag
);
  logic [DATA_W-1:0] ctlReg;
  logic [DATA_W-1:0] wrMask;
  logic              ctlWrite;

  assign ctlWrite = busWr && (busAddr == CTRL_ADDR);
  // a frozen sensitivity bit drops out of the write mask
  assign wrMask = (specialMode || !lockFlag) ? FULL_MASK : EN_MASK;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlReg   <= RESET_VAL;
      lockFlag <= 1'b0;
    end else if (ctlWrite) begin
      ctlReg <= (ctlReg & ~wrMask) | (busWdata & wrMask);
      if (!specialMode) lockFlag <= 1'b1;
    end
  end

  always_comb begin
    busRdata = '0;
    if (busAddr == CTRL_ADDR)      busRdata = ctlReg;
    else if (busAddr == RSVD_ADDR) busRdata = '0;
  end

  assign ctlStrobe.sensEdge  = ctlReg[SENS_POS];
  assign ctlStrobe.pinEnable = ctlReg[EN_POS];
endmodule

// File: rtl/extirq_dp.sv
module extirq_dp
  import extirq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    pinN,
  input  logic    svcAck,
  input  irqCtl_t ctlStrobe,
  output logic    syncPin,
  output logic    edgeLatch,
  output logic    irqReq
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] syncChain;
  logic          prevPin;
  logic          fallSeen;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) syncChain[0] <= 1'b1;
          else       syncChain[0] <= pinN;
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) syncChain[g] <= 1'b1;
          else       syncChain[g] <= syncChain[g-1];
      end
    end
  endgenerate

  assign syncPin  = syncChain[LAST];
  assign fallSeen = prevPin && !syncPin;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevPin   <= 1'b1;
      edgeLatch <= 1'b0;
    end else begin
      prevPin <= syncPin;
      if (!ctlStrobe.pinEnable)                 edgeLatch <= 1'b0;
      else if (ctlStrobe.sensEdge && fallSeen)  edgeLatch <= 1'b1;
      else if (svcAck)                          edgeLatch <= 1'b0;
    end
  end

  always_comb begin
    irqReq = 1'b0;
    if (ctlStrobe.pinEnable)
      irqReq = ctlStrobe.sensEdge ? edgeLatch : !syncPin;
  end
endmodule

// File: rtl/extirq_ctrl.sv
module extirq_ctrl
  import extirq_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 5'h1E,
  parameter logic [ADDR_W-1:0] RSVD_ADDR = 5'h0F,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              specialMode,
  input  logic              pinN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata,
  input  logic              svcAck,
  output logic              irqReq
);
  irqCtl_t ctlStrobe;
  logic    lockFlag;
  logic    syncPin;
  logic    edgeLatch;

  extirq_ctl #(
    .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .RSVD_ADDR(RSVD_ADDR)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .specialMode(specialMode),
    .busAddr(busAddr), .busWr(busWr), .busWdata(busWdata),
    .busRdata(busRdata), .ctlStrobe(ctlStrobe), .lockFlag(lockFlag)
  );

  extirq_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .pinN(pinN), .svcAck(svcAck),
    .ctlStrobe(ctlStrobe), .syncPin(syncPin),
    .edgeLatch(edgeLatch), .irqReq(irqReq)
  );
endmodule

// File: rtl/extirq_chk.sv
module extirq_chk #(
  parameter int ADDR_W = 5,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 5'h1E,
  parameter logic [ADDR_W-1:0] RSVD_ADDR = 5'h0F
) (
  input logic              clk,
  input logic              rstN,
  input logic              specialMode,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWr,
  input logic [7:0]        busRdata,
  input logic              svcAck,
  input logic              irqReq,
  input logic              sensBit,
  input logic              enBit,
  input logic              lockFlag,
  input logic              syncPin,
  input logic              edgeLatch
);
  // R3: reserved location reads zero
  a_r3_rsvd_zero: assert property (@(posedge clk) disable iff (!rstN)
    busAddr == RSVD_ADDR |-> busRdata == 8'h00);
  // R1: unimplemented bits read zero
  a_r1_unused_zero: assert property (@(posedge clk) disable iff (!rstN)
    busAddr == CTRL_ADDR |-> busRdata[5:0] == 6'h00);
  // R4: level mode follows synchronised pin
  a_r4_level_req: assert property (@(posedge clk) disable iff (!rstN)
    enBit && !sensBit && !syncPin |-> irqReq);
  // R5: edge mode follows the latch
  a_r5_edge_req: assert property (@(posedge clk) disable iff (!rstN)
    enBit && sensBit && edgeLatch |-> irqReq);
  // R5: latch holds without service
  a_r5_latch_hold: assert property (@(posedge clk) disable iff (!rstN)
    enBit && edgeLatch && !svcAck |=> edgeLatch);
  // R6: service without a new edge clears
  a_r6_ack_clear: assert property (@(posedge clk) disable iff (!rstN)
    svcAck && syncPin |=> !edgeLatch);
  // R7: disabled pin keeps latch clear and no request
  a_r7_disabled: assert property (@(posedge clk) disable iff (!rstN)
    !enBit |=> !edgeLatch);
  a_r7_no_req: assert property (@(posedge clk) disable iff (!rstN)
    !enBit |-> !irqReq);
  // R9: frozen sensitivity in normal mode
  a_r9_lock_hold: assert property (@(posedge clk) disable iff (!rstN)
    !specialMode && lockFlag && busWr && busAddr == CTRL_ADDR |=> $stable(sensBit));
endmodule

bind extirq_ctrl extirq_chk #(
  .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .RSVD_ADDR(RSVD_ADDR)
) u_chk (
  .clk(clk), .rstN(rstN), .specialMode(specialMode), .busAddr(busAddr),
  .busWr(busWr), .busRdata(busRdata), .svcAck(svcAck), .irqReq(irqReq),
  .sensBit(ctlStrobe.sensEdge), .enBit(ctlStrobe.pinEnable),
  .lockFlag(lockFlag), .syncPin(syncPin), .edgeLatch(edgeLatch)
);

// File: tb/extirq_ctrl_bench.sv
module extirq_ctrl_bench;
  localparam logic [4:0] CTRL_A = 5'h1E;
  localparam logic [4:0] RSVD_A = 5'h0F;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic specialMode = 1'b0;
  logic pinN = 1'b1;
  logic [4:0] busAddr = CTRL_A;
  logic busWr = 1'b0;
  logic [7:0] busWdata = 8'h00;
  logic [7:0] busRdata;
  logic svcAck = 1'b0;
  logic irqReq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  extirq_ctrl u_extirq_ctrl (
    .clk(clk), .rstN(rstN), .specialMode(specialMode), .pinN(pinN),
    .busAddr(busAddr), .busWr(busWr), .busWdata(busWdata),
    .busRdata(busRdata), .svcAck(svcAck), .irqReq(irqReq)
  );

  // reference model built from the requirements
  logic mS1, mS2, mPrev, mLatch, mSens, mEn, mLock;
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mS1 <= 1; mS2 <= 1; mPrev <= 1; mLatch <= 0;
      mSens <= 0; mEn <= 1; mLock <= 0;
    end else begin
      mS1 <= pinN; mS2 <= mS1; mPrev <= mS2;
      if (!mEn) mLatch <= 0;
      else if (mSens && mPrev && !mS2) mLatch <= 1;
      else if (svcAck) mLatch <= 0;
      if (busWr && busAddr == CTRL_A) begin
        mEn <= busWdata[6];
        if (specialMode || !mLock) mSens <= busWdata[7];
        if (!specialMode) mLock <= 1;
      end
    end
  end

  function automatic logic [7:0] expRead(logic [4:0] a, logic s, logic e);
    return (a == CTRL_A) ? {s, e, 6'b0} : 8'h00;
  endfunction

  function automatic logic expIrq(logic e, logic s, logic pinSync, logic lat);
    return e && (s ? lat : !pinSync);
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 0; busWr = 0; svcAck = 0; pinN = 1;
    tick(); tick();
    rstN = 1;
    tick();
  endtask

  task automatic wr(logic [4:0] a, logic [7:0] d);
    busAddr = a; busWdata = d; busWr = 1;
    tick();
    busWr = 0; busAddr = CTRL_A;
  endtask

  task automatic modelCheck();
    check("R1 read", busRdata, expRead(busAddr, mSens, mEn));
    check(mSens ? "R5 edge req" : "R4 level req", {7'b0, irqReq},
          {7'b0, expIrq(mEn, mSens, mS2, mLatch)});
  endtask

  initial begin
    @(negedge clk);
    doReset();
    // R2 reset state
    busAddr = CTRL_A;
    #1 check("R2 reset value", busRdata, 8'h40);
    check("R2 reset irq", {7'b0, irqReq}, 8'h00);
    // R3 reserved address
    wr(RSVD_A, 8'hFF);
    busAddr = RSVD_A; #1 check("R3 reserved zero", busRdata, 8'h00);
    busAddr = CTRL_A; #1 check("R3 write no effect", busRdata, 8'h40);

    // R4 level latency
    pinN = 0; tick();
    check("R4 one edge no req", {7'b0, irqReq}, 8'h00);
    tick();
    check("R4 req after sync", {7'b0, irqReq}, 8'h01);
    pinN = 1; tick(); tick();
    check("R4 release", {7'b0, irqReq}, 8'h00);

    // R9 lock in normal mode
    wr(CTRL_A, 8'h40);
    wr(CTRL_A, 8'hFF);
    #1 check("R9 sens frozen R1 low bits", busRdata, 8'h40);
    wr(CTRL_A, 8'h80);
    #1 check("R9 enable still writable", busRdata, 8'h00);

    // R8 special mode
    doReset();
    specialMode = 1;
    wr(CTRL_A, 8'h80);
    #1 check("R8 first write", busRdata, 8'h80);
    wr(CTRL_A, 8'hC0);
    wr(CTRL_A, 8'h40);
    #1 check("R8 rewrite", busRdata, 8'h40);

    // R5 edge capture
    wr(CTRL_A, 8'hC0);
    pinN = 0; tick(); tick();
    check("R5 not yet", {7'b0, irqReq}, 8'h00);
    tick();
    check("R5 captured", {7'b0, irqReq}, 8'h01);
    pinN = 1; tick(); tick(); tick();
    check("R5 held after release", {7'b0, irqReq}, 8'h01);
    // R6 service clears
    svcAck = 1; tick(); svcAck = 0;
    check("R6 ack clears", {7'b0, irqReq}, 8'h00);
    // R6 ack collides with new edge
    pinN = 0; tick(); tick();
    svcAck = 1; tick(); svcAck = 0;
    check("R6 edge wins over ack", {7'b0, irqReq}, 8'h01);
    // R7 disable clears, no return on re-enable
    pinN = 1; tick(); tick();
    wr(CTRL_A, 8'h80);
    check("R7 disabled no req", {7'b0, irqReq}, 8'h00);
    tick();
    wr(CTRL_A, 8'hC0);
    tick();
    check("R7 no stale edge", {7'b0, irqReq}, 8'h00);
    // R7 edge ignored while disabled
    wr(CTRL_A, 8'h80);
    pinN = 0; tick(); tick(); tick();
    wr(CTRL_A, 8'hC0);
    tick();
    check("R7 edge while disabled ignored", {7'b0, irqReq}, 8'h00);
    pinN = 1;

    // random phases against the model
    void'($urandom(32'h1234_5678));
    for (int ph = 0; ph < 2; ph++) begin
      doReset();
      specialMode = ph[0];
      for (int i = 0; i < 3000; i++) begin
        modelCheck();
        if ($urandom_range(3) == 0) pinN = ~pinN;
        svcAck = ($urandom_range(5) == 0);
        busWr = ($urandom_range(7) == 0);
        case ($urandom_range(3))
          0, 1: busAddr = CTRL_A;
          2: busAddr = RSVD_A;
          default: busAddr = 5'($urandom);
        endcase
        busWdata = 8'($urandom);
        tick();
      end
      busWr = 0; svcAck = 0;
    end
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule